// File: doc/BRIEF.md
# Program Memory Protection Controller

This block sits between every path that can reach on-chip program memory and the memory array itself. Three kinds of requester share one request port: the external serial programming port, internal table reads and data-space-window reads, and self-write requests from running code. Each request is judged against a two-bit protection fuse pair and the target address. The block answers one cycle later with grant or deny. On a grant it forwards a single read or write strobe to the array.

A separate command port handles the fuse pair and the erase operations. Fuses may be written only while both are unprogrammed. Once either fuse is programmed, the only way back is a full chip erase, and a protected part accepts that erase only while the supply-OK input is high. A user-region erase clears everything except the interrupt vector table. After that erase, programming of the code-protected region is allowed again. The array, the serialisation of the programming port and the analog supply detector are outside the block.

Top module: `progmem_guard`

## Requirements
- R1: After reset, fuse_state is 2'b11 and rsp_valid, rsp_grant, rsp_err, mem_rd_stb, mem_wr_stb, cmd_done, cmd_err and ers_stb are all 0.
- R2: fuse_state[1] is the code-protect fuse and fuse_state[0] is the write-protect fuse. A fuse is active when it is 0, and 2'b11 is the open (erased) state.
- R3: With code-protect active, a read from source 2'b00 (external port) at an address above 0x0000FE is denied. A read at 0x000000..0x0000FE is granted to every source whatever the fuses hold.
- R4: Reads from source 2'b01 (table read) and source 2'b10 (data-space window) at any in-range address are granted whatever the fuses hold. Source 2'b11 is a self-write requester.
- R5: With write-protect active, every write request is denied, at any address and from any source.
- R6: With code-protect active, a write above 0x0000FE is denied until a user-region erase has completed after the fuse was set. From then on such writes are granted, provided write-protect is inactive.
- R7: cmd_op 2'b00 (fuse write) loads cmd_fuse into fuse_state at the end of the command cycle, but only if fuse_state is 2'b11; otherwise the command raises cmd_err and fuse_state is unchanged. cmd_op 2'b11 always raises cmd_err.
- R8: cmd_op 2'b01 (full chip erase) is accepted when fuse_state is 2'b11 or supply_ok is 1; otherwise it raises cmd_err with no erase. When accepted, it sets fuse_state to 2'b11 and pulses ers_stb with ers_lo=0 and ers_hi=MEM_LAST.
- R9: cmd_op 2'b10 (user-region erase) is always accepted. It pulses ers_stb with ers_lo=VEC_LAST+1 and ers_hi=MEM_LAST and raises cmd_done.
- R10: A denied request raises rsp_err for one cycle, drives rsp_rdata to 0 and issues no memory strobe. A granted read pulses mem_rd_stb and returns mem_rdata on rsp_rdata; a granted write pulses mem_wr_stb with the request's address and data.
- R11: A request at an address above MEM_LAST (default 0x003FFF) is denied.
- R12: The response to a request appears exactly one cycle after it. A request in the same cycle as a fuse write is judged against the fuse value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present this cycle |
| req_src | input | 2 | Requester: 00 external port, 01 table read, 10 window read, 11 self-write |
| req_write | input | 1 | 1 for write/program, 0 for read |
| req_addr | input | ADDR_W | Program memory address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request granted |
| rsp_err | output | 1 | Request denied |
| rsp_rdata | output | DATA_W | Read data, zero unless a read was granted |
| mem_rd_stb | output | 1 | Read strobe to array |
| mem_wr_stb | output | 1 | Write strobe to array |
| mem_addr | output | ADDR_W | Array address for the strobe |
| mem_wdata | output | DATA_W | Array write data |
| mem_rdata | input | DATA_W | Array read data for mem_addr |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 fuse write, 01 full chip erase, 10 user-region erase, 11 reserved |
| cmd_fuse | input | 2 | New fuse pair for a fuse write |
| supply_ok | input | 1 | Supply is at or above the erase threshold |
| cmd_done | output | 1 | Command accepted |
| cmd_err | output | 1 | Command rejected |
| ers_stb | output | 1 | Erase strobe to array |
| ers_lo | output | ADDR_W | First erased address |
| ers_hi | output | ADDR_W | Last erased address |
| fuse_state | output | 2 | Current fuse pair |

## Verification
The assertions take the inputs to be known, meaning free of X and Z, once reset has been released. They expect supply_ok to be meaningful in every cycle that carries a full-chip-erase command. They take mem_rdata as a pure function of mem_addr, so a granted read's data can be related to the address. The bench drives every input on the falling edge and keeps them stable across the rising edge. It sends only the four defined source codes and holds the mem_rdata pattern fixed. Requests and commands are sometimes issued together, so that the old-fuse rule in R12 is exercised.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
    typedef enum logic [1:0] {
        SRC_EXT    = 2'b00,
        SRC_TABLE  = 2'b01,
        SRC_WINDOW = 2'b10,
        SRC_SELF   = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        OP_FUSE_WR    = 2'b00,
        OP_ERASE_ALL  = 2'b01,
        OP_ERASE_USER = 2'b10,
        OP_RSVD       = 2'b11
    } cmd_e;

    localparam logic [1:0] FUSE_OPEN = 2'b11;
endpackage

// File: rtl/pmg_access_check.sv
module pmg_access_check
    import pmg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] VEC_LAST = 'h0000FE,
    parameter logic [ADDR_W-1:0] MEM_LAST = 'h003FFF
) (
    input  src_e              src,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        fuse,
    input  logic              user_blank,
    output logic              allow
);
    logic cp_on;
    logic wp_on;
    logic in_vec;
    logic in_mem;

    always_comb begin
        cp_on  = ~fuse[1];
        wp_on  = ~fuse[0];
        in_vec = (addr <= VEC_LAST);
        in_mem = (addr <= MEM_LAST);
        if (!in_mem) begin
            allow = 1'b0;
        end else if (!is_write) begin
            allow = !(src == SRC_EXT && cp_on && !in_vec);
        end else begin
            allow = !wp_on && !(cp_on && !in_vec && !user_blank);
        end
    end
endmodule

// File: rtl/pmg_fuse_ctrl.sv
module pmg_fuse_ctrl
    import pmg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] VEC_LAST = 'h0000FE,
    parameter logic [ADDR_W-1:0] MEM_LAST = 'h003FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_e              cmd_op,
    input  logic [1:0]        cmd_fuse,
    input  logic              supply_ok,
    output logic [1:0]        fuse_q,
    output logic              user_blank,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic              ers_stb,
    output logic [ADDR_W-1:0] ers_lo,
    output logic [ADDR_W-1:0] ers_hi
);
    localparam logic [ADDR_W-1:0] USER_FIRST = VEC_LAST + ADDR_W'(1);

    typedef struct packed {
        logic [1:0]        fuse;
        logic              blank;
        logic              done;
        logic              err;
        logic              ers;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } fstate_t;

    fstate_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.err   = 1'b0;
        s_d.ers   = 1'b0;
        s_d.lo    = '0;
        s_d.hi    = '0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_FUSE_WR: begin
                    if (s_q.fuse == FUSE_OPEN) begin
                        s_d.fuse  = cmd_fuse;
                        s_d.blank = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.err   = 1'b1;
                    end
                end
                OP_ERASE_ALL: begin
                    if (s_q.fuse == FUSE_OPEN || supply_ok) begin
                        s_d.fuse  = FUSE_OPEN;
                        s_d.blank = 1'b1;
                        s_d.ers   = 1'b1;
                        s_d.lo    = '0;
                        s_d.hi    = MEM_LAST;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.err   = 1'b1;
                    end
                end
                OP_ERASE_USER: begin
                    s_d.blank = 1'b1;
                    s_d.ers   = 1'b1;
                    s_d.lo    = USER_FIRST;
                    s_d.hi    = MEM_LAST;
                    s_d.done  = 1'b1;
                end
                default: begin
                    s_d.err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.fuse  <= FUSE_OPEN;
            s_q.blank <= 1'b0;
            s_q.done  <= 1'b0;
            s_q.err   <= 1'b0;
            s_q.ers   <= 1'b0;
            s_q.lo    <= '0;
            s_q.hi    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fuse_q     = s_q.fuse;
    assign user_blank = s_q.blank;
    assign cmd_done   = s_q.done;
    assign cmd_err    = s_q.err;
    assign ers_stb    = s_q.ers;
    assign ers_lo     = s_q.lo;
    assign ers_hi     = s_q.hi;

    // R7: a programmed pair stays put unless a qualified chip erase arrives
    assert_pair_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_q != FUSE_OPEN && !(cmd_valid && cmd_op == OP_ERASE_ALL && supply_ok))
        |=> $stable(fuse_q));

    // R8: protected part with low supply rejects the chip erase
    assert_low_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE_ALL && fuse_q != FUSE_OPEN && !supply_ok)
        |=> (cmd_err && !ers_stb && fuse_q != FUSE_OPEN));

    // R8: an accepted chip erase opens the fuses and wipes from address zero
    assert_erase_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE_ALL && supply_ok)
        |=> (fuse_q == FUSE_OPEN && ers_stb && ers_lo == '0 && ers_hi == MEM_LAST));

    // R9: user erase never touches the vector table
    assert_user_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_ERASE_USER) |=> (ers_stb && ers_lo > VEC_LAST && cmd_done));
endmodule

// File: rtl/pmg_req_pipe.sv
module pmg_req_pipe #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              allow,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_err,
    output logic              mem_rd_stb,
    output logic              mem_wr_stb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    typedef struct packed {
        logic              vld;
        logic              gnt;
        logic              err;
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } pstate_t;

    pstate_t p_d, p_q;

    always_comb begin
        p_d       = '0;
        p_d.vld   = req_valid;
        p_d.gnt   = req_valid && allow;
        p_d.err   = req_valid && !allow;
        p_d.rd    = p_d.gnt && !req_write;
        p_d.wr    = p_d.gnt && req_write;
        if (p_d.gnt) begin
            p_d.addr = req_addr;
        end
        if (p_d.wr) begin
            p_d.wdata = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rsp_valid  = p_q.vld;
    assign rsp_grant  = p_q.gnt;
    assign rsp_err    = p_q.err;
    assign mem_rd_stb = p_q.rd;
    assign mem_wr_stb = p_q.wr;
    assign mem_addr   = p_q.addr;
    assign mem_wdata  = p_q.wdata;

    // R12: exactly one response per request, one cycle later
    assert_resp_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R10: strobes only for granted requests, never both at once
    assert_strobe_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_stb || mem_wr_stb) |-> (rsp_valid && rsp_grant && !rsp_err));
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_stb, mem_wr_stb}));
endmodule

// File: rtl/progmem_guard.sv
module progmem_guard
    import pmg_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 24,
    parameter logic [ADDR_W-1:0] VEC_LAST = 'h0000FE,
    parameter logic [ADDR_W-1:0] MEM_LAST = 'h003FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_src,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_stb,
    output logic              mem_wr_stb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [1:0]        cmd_fuse,
    input  logic              supply_ok,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic              ers_stb,
    output logic [ADDR_W-1:0] ers_lo,
    output logic [ADDR_W-1:0] ers_hi,
    output logic [1:0]        fuse_state
);
    logic       user_blank;
    logic       allow;
    logic [1:0] fuse_q;

    pmg_fuse_ctrl #(
        .ADDR_W  (ADDR_W),
        .VEC_LAST(VEC_LAST),
        .MEM_LAST(MEM_LAST)
    ) u_fuse (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_e'(cmd_op)),
        .cmd_fuse  (cmd_fuse),
        .supply_ok (supply_ok),
        .fuse_q    (fuse_q),
        .user_blank(user_blank),
        .cmd_done  (cmd_done),
        .cmd_err   (cmd_err),
        .ers_stb   (ers_stb),
        .ers_lo    (ers_lo),
        .ers_hi    (ers_hi)
    );

    pmg_access_check #(
        .ADDR_W  (ADDR_W),
        .VEC_LAST(VEC_LAST),
        .MEM_LAST(MEM_LAST)
    ) u_check (
        .src       (src_e'(req_src)),
        .is_write  (req_write),
        .addr      (req_addr),
        .fuse      (fuse_q),
        .user_blank(user_blank),
        .allow     (allow)
    );

    pmg_req_pipe #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .allow     (allow),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_err   (rsp_err),
        .mem_rd_stb(mem_rd_stb),
        .mem_wr_stb(mem_wr_stb),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign fuse_state = fuse_q;
    assign rsp_rdata  = mem_rd_stb ? mem_rdata : '0;

    // R3: external reads past the vector table are blocked under code-protect
    assert_ext_read_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_src == 2'b00 && !fuse_state[1] && req_addr > VEC_LAST)
        |=> (rsp_valid && !rsp_grant));

    // R3: vector table reads are always open
    assert_vector_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr <= VEC_LAST) |=> rsp_grant);

    // R4: internal read paths ignore code-protect
    assert_internal_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_src == 2'b01 || req_src == 2'b10) && req_addr <= MEM_LAST)
        |=> rsp_grant);

    // R5: write-protect blocks every write
    assert_write_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !fuse_state[0]) |=> (rsp_err && !mem_wr_stb));

    // R10: denied responses carry zero data
    assert_deny_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_grant) |-> (rsp_err && rsp_rdata == '0));

    // R11: out-of-range addresses are refused
    assert_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr > MEM_LAST) |=> rsp_err);
endmodule

// File: tb/test_progmem_guard.sv
`timescale 1ns/1ps
module test_progmem_guard;
    localparam int AW = 24;
    localparam int DW = 24;
    localparam int VEC_TOP = 'h0000FE;
    localparam int MEM_TOP = 'h003FFF;
    localparam logic [DW-1:0] PAT = 24'h5A5A5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_src = 2'b00;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, rsp_grant, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic          mem_rd_stb, mem_wr_stb;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [1:0]    cmd_fuse = 2'b11;
    logic          supply_ok = 1'b0;
    logic          cmd_done, cmd_err, ers_stb;
    logic [AW-1:0] ers_lo, ers_hi;
    logic [1:0]    fuse_state;

    always #2 clk = ~clk;

    assign mem_rdata = mem_addr ^ PAT;

    progmem_guard i_progmem_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_src(req_src), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_fuse(cmd_fuse),
        .supply_ok(supply_ok), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .ers_stb(ers_stb), .ers_lo(ers_lo), .ers_hi(ers_hi),
        .fuse_state(fuse_state)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R1";

    // ---------------- reference model ----------------
    int    m_fuse = 3;
    bit    m_blank = 0;
    bit    seen_edge = 0;
    string exp_tag = "R1";
    bit    e_rv, e_gnt, e_err, e_rd, e_wr, e_done, e_cerr, e_ers;
    int    e_maddr, e_wdata, e_lo, e_hi;

    function automatic bit model_allow(int src, bit wr, int addr, int f, bit blank);
        bit cp = (f & 2) == 0;
        bit wp = (f & 1) == 0;
        if (addr > MEM_TOP) return 0;
        if (!wr) return !(src == 0 && cp && addr > VEC_TOP);
        if (wp) return 0;
        if (cp && addr > VEC_TOP && !blank) return 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        seen_edge = 1;
        exp_tag = cur_tag;
        if (!rst_n) begin
            m_fuse = 3; m_blank = 0;
            {e_rv, e_gnt, e_err, e_rd, e_wr, e_done, e_cerr, e_ers} = '0;
            e_maddr = 0; e_wdata = 0; e_lo = 0; e_hi = 0;
        end else begin
            bit g;
            g = model_allow(int'(req_src), req_write, int'(req_addr), m_fuse, m_blank);
            e_rv = req_valid;
            e_gnt = req_valid && g;
            e_err = req_valid && !g;
            e_rd = e_gnt && !req_write;
            e_wr = e_gnt && req_write;
            e_maddr = e_gnt ? int'(req_addr) : 0;
            e_wdata = e_wr ? int'(req_wdata) : 0;
            e_done = 0; e_cerr = 0; e_ers = 0; e_lo = 0; e_hi = 0;
            if (cmd_valid) begin
                case (cmd_op)
                    2'd0: if (m_fuse == 3) begin
                              m_fuse = int'(cmd_fuse); m_blank = 0; e_done = 1;
                          end else e_cerr = 1;
                    2'd1: if (m_fuse == 3 || supply_ok) begin
                              m_fuse = 3; m_blank = 1; e_done = 1;
                              e_ers = 1; e_lo = 0; e_hi = MEM_TOP;
                          end else e_cerr = 1;
                    2'd2: begin
                              m_blank = 1; e_done = 1; e_ers = 1;
                              e_lo = VEC_TOP + 1; e_hi = MEM_TOP;
                          end
                    default: e_cerr = 1;
                endcase
            end
        end
    end

    task automatic chk(string name, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", exp_tag, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (seen_edge) begin
            chk("rsp_valid", rsp_valid, e_rv);
            chk("rsp_grant", rsp_grant, e_gnt);
            chk("rsp_err", rsp_err, e_err);
            chk("mem_rd_stb", mem_rd_stb, e_rd);
            chk("mem_wr_stb", mem_wr_stb, e_wr);
            chk("mem_addr", mem_addr, e_maddr);
            chk("mem_wdata", mem_wdata, e_wdata);
            chk("rsp_rdata", rsp_rdata, e_rd ? (e_maddr ^ int'(PAT)) : 0);
            chk("cmd_done", cmd_done, e_done);
            chk("cmd_err", cmd_err, e_cerr);
            chk("ers_stb", ers_stb, e_ers);
            chk("ers_lo", ers_lo, e_lo);
            chk("ers_hi", ers_hi, e_hi);
            chk("fuse_state", fuse_state, m_fuse);
        end
    end

    // ---------------- stimulus ----------------
    task automatic put_req(logic [1:0] s, logic w, logic [AW-1:0] a, string t);
        @(negedge clk);
        cur_tag = t;
        req_valid = 1'b1; req_src = s; req_write = w; req_addr = a;
        req_wdata = a ^ 24'h0F0F0F;
        cmd_valid = 1'b0;
    endtask

    task automatic put_cmd(logic [1:0] op, logic [1:0] f, logic sup, string t);
        @(negedge clk);
        cur_tag = t;
        req_valid = 1'b0;
        cmd_valid = 1'b1; cmd_op = op; cmd_fuse = f; supply_ok = sup;
    endtask

    task automatic put_idle(string t);
        @(negedge clk);
        cur_tag = t;
        req_valid = 1'b0; cmd_valid = 1'b0; supply_ok = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        put_idle("R1");
        // open part: everything in range goes through
        put_req(2'b00, 1'b0, 24'h000100, "R3");
        put_req(2'b11, 1'b1, 24'h000200, "R6");
        put_req(2'b00, 1'b0, 24'h004000, "R11");
        put_req(2'b11, 1'b1, 24'hFFFFFF, "R11");
        put_req(2'b01, 1'b0, 24'h003FFF, "R4");
        // set code-protect with a request in the same cycle
        put_cmd(2'b00, 2'b01, 1'b0, "R12");
        req_valid = 1'b1; req_src = 2'b00; req_write = 1'b0; req_addr = 24'h000100;
        put_req(2'b00, 1'b0, 24'h000100, "R3");
        put_req(2'b00, 1'b0, 24'h0000FE, "R3");
        put_req(2'b00, 1'b0, 24'h0000FF, "R3");
        put_req(2'b01, 1'b0, 24'h000100, "R4");
        put_req(2'b10, 1'b0, 24'h003FFF, "R4");
        put_req(2'b00, 1'b1, 24'h000100, "R6");
        put_req(2'b11, 1'b1, 24'h000300, "R6");
        put_req(2'b00, 1'b1, 24'h000010, "R6");
        put_cmd(2'b00, 2'b11, 1'b1, "R7");
        put_cmd(2'b11, 2'b11, 1'b1, "R7");
        put_req(2'b00, 1'b0, 24'h000100, "R2");
        put_cmd(2'b10, 2'b00, 1'b0, "R9");
        put_req(2'b00, 1'b1, 24'h000100, "R6");
        put_req(2'b00, 1'b0, 24'h000100, "R3");
        put_cmd(2'b01, 2'b00, 1'b0, "R8");
        put_req(2'b00, 1'b0, 24'h000180, "R8");
        put_cmd(2'b01, 2'b00, 1'b1, "R8");
        put_req(2'b00, 1'b0, 24'h000180, "R8");
        // write-protect only
        put_cmd(2'b00, 2'b10, 1'b0, "R5");
        put_req(2'b11, 1'b1, 24'h000010, "R5");
        put_req(2'b00, 1'b1, 24'h000100, "R5");
        put_req(2'b00, 1'b0, 24'h000100, "R5");
        put_cmd(2'b10, 2'b00, 1'b0, "R9");
        put_req(2'b11, 1'b1, 24'h000100, "R5");
        put_cmd(2'b00, 2'b11, 1'b1, "R7");
        put_cmd(2'b01, 2'b00, 1'b1, "R8");
        // open part, chip erase without supply still accepted
        put_cmd(2'b01, 2'b00, 1'b0, "R8");
        // both fuses active
        put_cmd(2'b00, 2'b00, 1'b0, "R2");
        put_req(2'b00, 1'b0, 24'h000020, "R3");
        put_req(2'b10, 1'b0, 24'h002000, "R4");
        put_req(2'b00, 1'b0, 24'h002000, "R10");
        put_req(2'b11, 1'b1, 24'h000020, "R10");
        put_cmd(2'b01, 2'b00, 1'b0, "R8");
        put_cmd(2'b01, 2'b00, 1'b1, "R8");
        put_req(2'b00, 1'b1, 24'h002000, "R10");
        put_idle("R12");
        put_idle("R12");
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule